// File: doc/BRIEF.md
# External interrupt sense controller

This block conditions up to eight external request pins for a CPU. Each pin is brought into the clock domain by a two-flop synchroniser and then judged against a per-line sense mode: low level, any change, falling edge or rising edge. In the edge modes a detected event sets a pending bit. The bit holds until software writes a one to it or the CPU acknowledges that line's vector. In low-level mode no pending bit is kept, and the request follows the synchronised pin directly.

Each line drives its own request output. A line's request goes out only when its enable bit is set and the global interrupt enable input is high. Software sets up the block through a small register bus. Two sense registers hold two bits per line. An enable register holds one bit per line. A pending register is read to see the pending bits and written to clear them. The recommended way to reconfigure a line is: disable it, change its mode, clear its pending bit, then enable it again.

Top module: `extint_sense`

## Requirements
- R1: After reset every request output is 0, and all four registers read 0.
- R2: Sense code 2'b10 (falling) sets the line's pending bit on a 1-to-0 transition of the synchronised pin and not on a 0-to-1 transition.
- R3: Sense code 2'b11 (rising) sets the pending bit on a 0-to-1 transition only.
- R4: Sense code 2'b01 (change) sets the pending bit on every transition in either direction.
- R5: Under sense code 2'b00 (low level), the line's request is high for as long as the synchronised pin is low. It rises two clock edges after the pin falls, and the pending bit reads 0.
- R6: Register addresses are 0 for sense A, 1 for sense B, 2 for enable and 3 for pending. Line n (n<4) uses sense A bits [2n+1:2n]. Line n (n>=4) uses sense B bits [2(n-4)+1:2(n-4)]. Enable and pending use bit n. Read data is registered and appears one clock after the address is presented.
- R7: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R8: A one-cycle acknowledge pulse on a line clears that line's pending bit.
- R9: A line's request is high only when its enable bit is 1, the global enable input is 1, and the line has a pending bit or an active low level.
- R10: If an event and a clear (write-one or acknowledge) reach the same pending bit in the same cycle, the bit ends up set.
- R11: Switching a line from falling to rising while its pin is high sets a spurious pending bit. The sequence disable, change mode, write-one clear, enable leaves the request low.
- R12: In edge modes, a pin transition made before clock edge k raises the request after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_LINES | Asynchronous external request pins |
| gie | input | 1 | Global interrupt enable |
| ack | input | N_LINES | Per-line vector acknowledge from the CPU |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | N_LINES | Per-line interrupt request |

## Verification
A wrong pending bit appears on the pending register read one clock after the address is presented. If the line is enabled, it also appears at once on that line's request output. A fault in the synchroniser or edge history shifts the request by a cycle or produces an edge of the wrong polarity. The bench catches this by sampling the request exactly at the second and third falling clock edges after a pin change. A bad sense field or a lost set-versus-clear race shows up as a pending bit that is present or missing on the next read.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int REG_W         = 8;
    localparam int ADDR_W        = 2;
    localparam int LINES_PER_REG = REG_W / 2;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [ADDR_W-1:0] {
        ADR_SENSE_A = 2'd0,
        ADR_SENSE_B = 2'd1,
        ADR_ENABLE  = 2'd2,
        ADR_PENDING = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } samp_t;

    typedef struct packed {
        logic pending;
        logic level_req;
    } line_stat_t;

    // Condition whose rise marks an event in the single-edge modes.
    function automatic logic active_term(sense_e mode, logic s);
        case (mode)
            SENSE_RISE: return s;
            SENSE_ANY:  return s;
            default:    return ~s;
        endcase
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync
    import extint_pkg::*;
#(
    parameter int   W       = 8,
    parameter logic IDLE_LV = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output samp_t        samp [W]
);
    logic [W-1:0] meta_q, cur_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= {W{IDLE_LV}};
            cur_q  <= {W{IDLE_LV}};
            prev_q <= {W{IDLE_LV}};
        end else begin
            meta_q <= din;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_out
        assign samp[i] = '{cur: cur_q[i], prev: prev_q[i]};
    end
endmodule

// File: rtl/extint_line.sv
module extint_line
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sense_e     mode,
    input  samp_t      samp,
    input  logic       clr_i,
    input  logic       ack_i,
    output line_stat_t stat
);
    logic act_now, act_q, hit, pend_q;

    assign act_now = active_term(mode, samp.cur);
    assign hit     = (mode == SENSE_ANY) ? (samp.cur ^ samp.prev)
                                         : (act_now & ~act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            act_q <= act_now;
            if (mode == SENSE_LOW)    pend_q <= 1'b0;
            else if (hit)             pend_q <= 1'b1;
            else if (clr_i || ack_i)  pend_q <= 1'b0;
        end
    end

    assign stat = '{pending: pend_q, level_req: (mode == SENSE_LOW) & ~samp.cur};

    AST_LOW_NO_PEND: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_LOW) |=> !pend_q); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit && mode != SENSE_LOW) |=> pend_q); // R10
    AST_SET_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(hit)); // R2
    AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_q) |-> $past(clr_i || ack_i || mode == SENSE_LOW)); // R7
endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic               we_i,
    input  logic [N_LINES-1:0] pend_i,
    output sense_e             mode_o [N_LINES],
    output logic [N_LINES-1:0] enable_o,
    output logic [N_LINES-1:0] w1c_o,
    output logic [REG_W-1:0]   rdata_o
);
    logic [1:0]         sense_q [N_LINES];
    logic [N_LINES-1:0] enable_q;
    logic [REG_W-1:0]   rd_sa, rd_sb, rd_en, rd_pd, rd_mux;

    for (genvar n = 0; n < N_LINES; n++) begin : g_sense
        localparam int BANK = n / LINES_PER_REG;
        localparam int SLOT = n % LINES_PER_REG;
        always_ff @(posedge clk) begin
            if (rst)
                sense_q[n] <= 2'b00;
            else if (we_i && addr_i == ADDR_W'(BANK))
                sense_q[n] <= wdata_i[2*SLOT +: 2];
        end
        assign mode_o[n] = sense_e'(sense_q[n]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            enable_q <= '0;
        else if (we_i && reg_addr_e'(addr_i) == ADR_ENABLE)
            enable_q <= wdata_i[N_LINES-1:0];
    end

    assign enable_o = enable_q;
    assign w1c_o    = (we_i && reg_addr_e'(addr_i) == ADR_PENDING)
                      ? wdata_i[N_LINES-1:0] : '0;

    always_comb begin
        rd_sa = '0;
        rd_sb = '0;
        rd_en = '0;
        rd_pd = '0;
        for (int n = 0; n < N_LINES; n++) begin
            if (n < LINES_PER_REG) rd_sa[2*n +: 2] = sense_q[n];
            else                   rd_sb[2*(n-LINES_PER_REG) +: 2] = sense_q[n];
            rd_en[n] = enable_q[n];
            rd_pd[n] = pend_i[n];
        end
        case (reg_addr_e'(addr_i))
            ADR_SENSE_A: rd_mux = rd_sa;
            ADR_SENSE_B: rd_mux = rd_sb;
            ADR_ENABLE:  rd_mux = rd_en;
            default:     rd_mux = rd_pd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_o <= '0;
        else     rdata_o <= rd_mux;
    end
endmodule

// File: rtl/extint_sense.sv
module extint_sense
    import extint_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] pin_in,
    input  logic               gie,
    input  logic [N_LINES-1:0] ack,
    input  logic [1:0]         bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic               bus_we,
    output logic [7:0]         bus_rdata,
    output logic [N_LINES-1:0] irq
);
    samp_t              samp   [N_LINES];
    sense_e             mode   [N_LINES];
    line_stat_t         stat   [N_LINES];
    logic [N_LINES-1:0] enable, w1c, pend, src;

    extint_sync #(.W(N_LINES), .IDLE_LV(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .samp (samp)
    );

    extint_regs #(.N_LINES(N_LINES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .we_i     (bus_we),
        .pend_i   (pend),
        .mode_o   (mode),
        .enable_o (enable),
        .w1c_o    (w1c),
        .rdata_o  (bus_rdata)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        extint_line u_line (
            .clk   (clk),
            .rst   (rst),
            .mode  (mode[i]),
            .samp  (samp[i]),
            .clr_i (w1c[i]),
            .ack_i (ack[i]),
            .stat  (stat[i])
        );
        assign pend[i] = stat[i].pending;
        assign src[i]  = stat[i].pending | stat[i].level_req;
    end

    assign irq = {N_LINES{gie}} & enable & src;
endmodule

// File: tb/extint_sense_tb.sv
module extint_sense_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_in = '1;
    logic         gie = 1'b0;
    logic [N-1:0] ack = '0;
    logic [1:0]   bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_rdata;
    logic [N-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    extint_sense #(.N_LINES(N)) u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .gie(gie), .ack(ack),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_pend(logic [15:0] modes, logic [7:0] a, logic [7:0] b);
        logic [7:0] r = '0;
        for (int i = 0; i < N; i++) begin
            case (modes[2*i +: 2])
                2'b01:   r[i] = a[i] ^ b[i];
                2'b10:   r[i] = a[i] & ~b[i];
                2'b11:   r[i] = ~a[i] & b[i];
                default: r[i] = 1'b0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [7:0] low_lines(logic [15:0] modes);
        logic [7:0] r = '0;
        for (int i = 0; i < N; i++) r[i] = (modes[2*i +: 2] == 2'b00);
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        idle(3);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", irq, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reg", d, 0);
        end
        gie = 1'b1;

        // R12 / R2 falling edge on line 0
        wr(0, 8'h02); wr(2, 8'h01); idle(3); wr(3, 8'hFF);
        pin_in[0] = 1'b0;
        @(negedge clk); check("R12 irq early1", irq[0], 0);
        @(negedge clk); check("R12 irq early2", irq[0], 0);
        @(negedge clk); check("R12 irq on time", irq[0], 1);
        rd(3, d); check("R2 fall sets", d, 8'h01);
        wr(3, 8'h01); pin_in[0] = 1'b1; idle(4);
        rd(3, d); check("R2 rise ignored", d, 8'h00);

        // R3 rising
        wr(0, 8'h03); idle(3); wr(3, 8'hFF);
        pin_in[0] = 1'b0; idle(4);
        rd(3, d); check("R3 fall ignored", d, 8'h00);
        pin_in[0] = 1'b1; idle(4);
        rd(3, d); check("R3 rise sets", d, 8'h01);

        // R4 change
        wr(0, 8'h01); idle(3); wr(3, 8'hFF);
        pin_in[0] = 1'b0; idle(4);
        rd(3, d); check("R4 fall sets", d, 8'h01);
        wr(3, 8'h01);
        pin_in[0] = 1'b1; idle(4);
        rd(3, d); check("R4 rise sets", d, 8'h01);

        // R7 write-one clear
        wr(3, 8'h00); rd(3, d); check("R7 zero no effect", d, 8'h01);
        wr(3, 8'h01); rd(3, d); check("R7 one clears", d, 8'h00);

        // R8 acknowledge
        pin_in[0] = 1'b0; idle(4);
        check("R8 irq before ack", irq[0], 1);
        ack[0] = 1'b1; @(negedge clk); ack[0] = 1'b0;
        check("R8 irq after ack", irq[0], 0);
        rd(3, d); check("R8 pend after ack", d, 8'h00);

        // R9 gating
        pin_in[0] = 1'b1; idle(4);
        gie = 1'b0; @(negedge clk); check("R9 gie off", irq[0], 0);
        gie = 1'b1; @(negedge clk); check("R9 gie on", irq[0], 1);
        wr(2, 8'h00); check("R9 enable off", irq[0], 0);
        rd(3, d); check("R9 pend kept", d, 8'h01);
        wr(3, 8'hFF); wr(2, 8'h01);

        // R10 set beats write-one clear in the same cycle
        pin_in[0] = 1'b0;
        idle(2);
        bus_addr = 2'd3; bus_wdata = 8'h01; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        rd(3, d); check("R10 set wins w1c", d, 8'h01);
        wr(3, 8'h01);
        // R10 set beats acknowledge in the same cycle
        pin_in[0] = 1'b1;
        idle(2);
        ack[0] = 1'b1;
        @(negedge clk); ack[0] = 1'b0;
        rd(3, d); check("R10 set wins ack", d, 8'h01);
        wr(3, 8'hFF);

        // R5 low level on line 1
        wr(0, 8'h01); wr(2, 8'h02); idle(3);
        check("R5 high pin idle", irq[1], 0);
        pin_in[1] = 1'b0;
        @(negedge clk); check("R5 early", irq[1], 0);
        @(negedge clk); check("R5 asserted", irq[1], 1);
        idle(3); check("R5 held", irq[1], 1);
        rd(3, d); check("R5 pend reads 0", d[1], 0);
        pin_in[1] = 1'b1; idle(2); check("R5 released", irq[1], 0);
        wr(2, 8'h00);

        // R11 spurious pending on reconfigure, line 2
        wr(0, 8'h20); idle(3); wr(3, 8'hFF);
        wr(0, 8'h30); idle(2);
        rd(3, d); check("R11 spurious pend", d[2], 1);
        wr(3, 8'h04); wr(2, 8'h04); idle(3);
        check("R11 no false irq", irq, 0);
        rd(3, d); check("R11 pend clean", d, 8'h00);
        wr(2, 8'h00);

        // R6 register map readback
        wr(0, 8'hA5); rd(0, d); check("R6 sense A", d, 8'hA5);
        wr(1, 8'h3C); rd(1, d); check("R6 sense B", d, 8'h3C);
        wr(2, 8'h96); rd(2, d); check("R6 enable", d, 8'h96);
        wr(2, 8'h00);

        // Random mixes across all lines (R2 R3 R4 R5 R6 R9)
        for (int it = 0; it < 40; it++) begin
            logic [7:0]  a, b, mk, ep;
            logic [15:0] modes;
            a = 8'($urandom); b = 8'($urandom);
            modes = 16'($urandom); mk = 8'($urandom);
            pin_in = a;
            wr(0, modes[7:0]); wr(1, modes[15:8]); wr(2, mk);
            idle(4); wr(3, 8'hFF);
            pin_in = b; idle(5);
            ep = exp_pend(modes, a, b);
            rd(3, d); check("R6 random pend", d, ep);
            check("R9 random irq", irq, mk & ((low_lines(modes) & ~b) | ep));
        end

        summary();
    end
endmodule